// File: doc/BRIEF.md
# USB Endpoint DMA Handshake Controller

This block sits between an external DMA controller and the endpoint buffers of a USB peripheral controller. A configuration write chooses one target endpoint, enables DMA, sets the burst length and the active levels of the request and acknowledge pins, and picks one of two handshake modes. The block raises the request pin when the chosen endpoint can move data. An OUT endpoint can move data when it holds bytes to read. An IN endpoint can move data when it has room to write. The block drops the request once the programmed number of bytes has been strobed, or sooner if the buffer can no longer move data.

While the acknowledge pin is active, every byte strobe goes to the DMA target. This holds whatever endpoint the processor's I/O path has selected. The processor keeps its own endpoint selection in a separate register, so DMA and I/O accesses can alternate without disturbing each other. There are two handshake modes:
- In strobe-qualified mode (separate memory and I/O spaces), a byte moves only when acknowledge and a read or write strobe are both active.
- In acknowledge-only mode (one shared address space), each new assertion of acknowledge is one byte.

Top module: `ep_dma_hs`

## Requirements
- R1: After reset DMA is disabled, `dreq_o` is 0, the burst length is one byte, both pin polarities are active-high, strobe-qualified mode is selected, and no endpoint is selected for I/O, so no strobe reaches any endpoint.
- R2: Endpoint codes 2 to 15 select endpoint bit (code-2) of every per-endpoint vector. Codes 0 and 1 select no DMA target: the request never asserts and no DMA strobe is routed.
- R3: The transfer direction is set by the target's `ep_dir_i` bit. With 0 (OUT), DMA bytes pulse `ep_rd_o`, and in strobe-qualified mode only `io_rd_i` counts. With 1 (IN), DMA bytes pulse `ep_wr_o`, and only `io_wr_i` counts.
- R4: The request becomes active one cycle after DMA is enabled and the target is ready and acknowledge is inactive. The target is ready when `ep_has_data_i` is set for an OUT endpoint, or `ep_has_space_i` for an IN endpoint. The request becomes inactive the cycle after readiness or the enable drops.
- R5: `cfg_blen_i` holds the bytes per request minus one (0 means a single cycle, 15 means 16 bytes). The request goes inactive the cycle after the last byte strobe of the burst. It returns only after acknowledge has gone inactive.
- R6: While acknowledge is active, a DMA strobe reaches only the target endpoint, in the same cycle. I/O strobes are not routed, and at most one endpoint is strobed in any cycle.
- R7: While acknowledge is inactive, `io_rd_i` and `io_wr_i` reach `ep_rd_o` and `ep_wr_o` of the endpoint last written through `io_sel_we_i`/`io_sel_i`, in the same cycle. That selection survives any DMA activity.
- R8: In strobe-qualified mode (`cfg_ack_only_i`=0), an active acknowledge with no read or write strobe moves no byte and does not shorten the burst.
- R9: In acknowledge-only mode (`cfg_ack_only_i`=1), each transition of acknowledge into its active level is one byte. That byte strobes the target for exactly the cycle in which acknowledge becomes active.
- R10: `cfg_req_hi_i`=0 makes `dreq_o` low when requesting and high otherwise. `cfg_ack_hi_i`=0 makes `dack_i` active when low.
- R11: A configuration write that names a new target while acknowledge is active or a burst is partly done keeps the old target. The new one takes over on the first cycle with no burst in progress. All other fields apply at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | DMA enable |
| cfg_ep_i | input | CODE_W | Target endpoint code |
| cfg_blen_i | input | 4 | Burst length minus one |
| cfg_ack_only_i | input | 1 | 1: acknowledge-only mode |
| cfg_req_hi_i | input | 1 | 1: request pin active-high |
| cfg_ack_hi_i | input | 1 | 1: acknowledge pin active-high |
| ep_dir_i | input | NUM_EP | Per-endpoint direction, 1 = IN |
| ep_has_data_i | input | NUM_EP | OUT buffer holds data |
| ep_has_space_i | input | NUM_EP | IN buffer has room |
| io_sel_we_i | input | 1 | I/O endpoint select write |
| io_sel_i | input | CODE_W | I/O endpoint code |
| io_rd_i | input | 1 | Read strobe |
| io_wr_i | input | 1 | Write strobe |
| dack_i | input | 1 | DMA acknowledge pin |
| dreq_o | output | 1 | DMA request pin |
| ep_rd_o | output | NUM_EP | Per-endpoint read strobes |
| ep_wr_o | output | NUM_EP | Per-endpoint write strobes |

## Verification
The bench retargets the DMA endpoint in the middle of a burst. A design that switched at once would strobe the new endpoint before the burst ends. It drives bursts of random length and counts strobes against the request pin. An off-by-one burst counter would drop the request one byte early or late. It holds acknowledge with no strobe in strobe-qualified mode, and holds it for several cycles in acknowledge-only mode. That catches designs that count level rather than edge, or count without a strobe. It also uses inverted polarities and the invalid codes 0 and 1. An unmasked polarity would show a request of the wrong level. A loose decoder would raise a request for a nonexistent endpoint.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
  localparam int unsigned EP_N      = 14;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned BLEN_W    = 4;
  localparam int unsigned CODE_BASE = 2;

  typedef struct packed {
    logic              en;
    logic              ack_only;
    logic              req_hi;
    logic              ack_hi;
    logic [BLEN_W-1:0] blen;
  } dma_mode_t;

  localparam dma_mode_t MODE_RST = '{en: 1'b0, ack_only: 1'b0, req_hi: 1'b1,
                                     ack_hi: 1'b1, blen: '0};
endpackage

// File: rtl/ep_dma_dec.sv
module ep_dma_dec #(
  parameter int unsigned NUM_EP = ep_dma_pkg::EP_N,
  parameter int unsigned CODE_W = ep_dma_pkg::CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [NUM_EP-1:0] hot_o
);
  localparam int unsigned BASE = ep_dma_pkg::CODE_BASE;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
    assign hot_o[i] = (code_i == CODE_W'(i + BASE));
  end
endmodule

// File: rtl/ep_dma_cfg.sv
module ep_dma_cfg #(
  parameter int unsigned CODE_W = ep_dma_pkg::CODE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  ep_dma_pkg::dma_mode_t mode_i,
  input  logic [CODE_W-1:0]     ep_i,
  input  logic                  busy_i,
  output ep_dma_pkg::dma_mode_t mode_o,
  output logic [CODE_W-1:0]     ep_o
);
  ep_dma_pkg::dma_mode_t mode_q;
  logic [CODE_W-1:0]     ep_q, pend_ep_q;
  logic                  pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= ep_dma_pkg::MODE_RST;
      ep_q      <= '0;
      pend_ep_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (wr_i) mode_q <= mode_i;
      // target swap waits for a quiet handshake
      if (wr_i && !busy_i) begin
        ep_q   <= ep_i;
        pend_q <= 1'b0;
      end else if (wr_i) begin
        pend_ep_q <= ep_i;
        pend_q    <= 1'b1;
      end else if (pend_q && !busy_i) begin
        ep_q   <= pend_ep_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign mode_o = mode_q;
  assign ep_o   = ep_q;
endmodule

// File: rtl/ep_dma_req.sv
module ep_dma_req #(
  parameter int unsigned NUM_EP = ep_dma_pkg::EP_N,
  parameter int unsigned BLEN_W = ep_dma_pkg::BLEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_hi_i,
  input  logic [BLEN_W-1:0] blen_i,
  input  logic [NUM_EP-1:0] tgt_hot_i,
  input  logic [NUM_EP-1:0] ep_dir_i,
  input  logic [NUM_EP-1:0] ep_has_data_i,
  input  logic [NUM_EP-1:0] ep_has_space_i,
  input  logic              dack_act_i,
  input  logic              dma_stb_i,
  output logic              dreq_o,
  output logic              tgt_dir_o,
  output logic              tgt_ready_o,
  output logic              busy_o
);
  logic              req_q, req_d;
  logic [BLEN_W-1:0] cnt_q, cnt_d;
  logic [NUM_EP-1:0] ready_vec;
  logic              last;

  assign ready_vec   = (ep_dir_i & ep_has_space_i) | (~ep_dir_i & ep_has_data_i);
  assign tgt_ready_o = |(tgt_hot_i & ready_vec);
  assign tgt_dir_o   = |(tgt_hot_i & ep_dir_i);
  // >= guards against a shorter length written mid-burst
  assign last        = dma_stb_i && (cnt_q >= blen_i);

  always_comb begin
    req_d = req_q;
    cnt_d = cnt_q;
    if (!en_i || !tgt_ready_o) begin
      req_d = 1'b0;
      cnt_d = '0;
    end else if (last) begin
      req_d = 1'b0;
      cnt_d = '0;
    end else if (dma_stb_i) begin
      cnt_d = cnt_q + 1'b1;
    end else if (!req_q && !dack_act_i) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = dack_act_i || (cnt_q != '0);
  assign dreq_o = req_q ^ ~req_hi_i;
endmodule

// File: rtl/ep_dma_route.sv
module ep_dma_route #(
  parameter int unsigned NUM_EP = ep_dma_pkg::EP_N,
  parameter int unsigned CODE_W = ep_dma_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_only_i,
  input  logic              ack_hi_i,
  input  logic              dack_i,
  input  logic [NUM_EP-1:0] tgt_hot_i,
  input  logic              tgt_dir_i,
  input  logic              io_sel_we_i,
  input  logic [CODE_W-1:0] io_sel_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  output logic [NUM_EP-1:0] ep_rd_o,
  output logic [NUM_EP-1:0] ep_wr_o,
  output logic              dma_stb_o,
  output logic              dack_act_o
);
  logic [CODE_W-1:0] io_q;
  logic [NUM_EP-1:0] io_hot;
  logic              ack_q, dack_act;

  assign dack_act = (dack_i == ack_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_q  <= '0;
      ack_q <= 1'b0;
    end else begin
      if (io_sel_we_i) io_q <= io_sel_i;
      ack_q <= dack_act;
    end
  end

  ep_dma_dec #(.NUM_EP(NUM_EP), .CODE_W(CODE_W)) u_io_dec (
    .code_i(io_q),
    .hot_o (io_hot)
  );

  assign dma_stb_o = ack_only_i ? (dack_act && !ack_q)
                                : (dack_act && (tgt_dir_i ? io_wr_i : io_rd_i));

  always_comb begin
    if (dack_act) begin
      ep_rd_o = tgt_dir_i ? '0 : (tgt_hot_i & {NUM_EP{dma_stb_o}});
      ep_wr_o = tgt_dir_i ? (tgt_hot_i & {NUM_EP{dma_stb_o}}) : '0;
    end else begin
      ep_rd_o = io_hot & {NUM_EP{io_rd_i}};
      ep_wr_o = io_hot & {NUM_EP{io_wr_i}};
    end
  end

  assign dack_act_o = dack_act;
endmodule

// File: rtl/ep_dma_hs.sv
module ep_dma_hs #(
  parameter int unsigned NUM_EP = ep_dma_pkg::EP_N,
  parameter int unsigned CODE_W = ep_dma_pkg::CODE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic                          cfg_en_i,
  input  logic [CODE_W-1:0]             cfg_ep_i,
  input  logic [ep_dma_pkg::BLEN_W-1:0] cfg_blen_i,
  input  logic                          cfg_ack_only_i,
  input  logic                          cfg_req_hi_i,
  input  logic                          cfg_ack_hi_i,
  input  logic [NUM_EP-1:0]             ep_dir_i,
  input  logic [NUM_EP-1:0]             ep_has_data_i,
  input  logic [NUM_EP-1:0]             ep_has_space_i,
  input  logic                          io_sel_we_i,
  input  logic [CODE_W-1:0]             io_sel_i,
  input  logic                          io_rd_i,
  input  logic                          io_wr_i,
  input  logic                          dack_i,
  output logic                          dreq_o,
  output logic [NUM_EP-1:0]             ep_rd_o,
  output logic [NUM_EP-1:0]             ep_wr_o
);
  localparam int unsigned BLEN_W = ep_dma_pkg::BLEN_W;

  ep_dma_pkg::dma_mode_t mode_in, mode_q;
  logic [CODE_W-1:0]     tgt_ep;
  logic [NUM_EP-1:0]     tgt_hot;
  logic                  tgt_dir, tgt_ready, busy, dma_stb, dack_act;

  assign mode_in = '{en: cfg_en_i, ack_only: cfg_ack_only_i, req_hi: cfg_req_hi_i,
                     ack_hi: cfg_ack_hi_i, blen: cfg_blen_i};

  ep_dma_cfg #(.CODE_W(CODE_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (cfg_we_i),
    .mode_i(mode_in),
    .ep_i  (cfg_ep_i),
    .busy_i(busy),
    .mode_o(mode_q),
    .ep_o  (tgt_ep)
  );

  ep_dma_dec #(.NUM_EP(NUM_EP), .CODE_W(CODE_W)) u_tgt_dec (
    .code_i(tgt_ep),
    .hot_o (tgt_hot)
  );

  ep_dma_req #(.NUM_EP(NUM_EP), .BLEN_W(BLEN_W)) u_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (mode_q.en),
    .req_hi_i      (mode_q.req_hi),
    .blen_i        (mode_q.blen),
    .tgt_hot_i     (tgt_hot),
    .ep_dir_i      (ep_dir_i),
    .ep_has_data_i (ep_has_data_i),
    .ep_has_space_i(ep_has_space_i),
    .dack_act_i    (dack_act),
    .dma_stb_i     (dma_stb),
    .dreq_o        (dreq_o),
    .tgt_dir_o     (tgt_dir),
    .tgt_ready_o   (tgt_ready),
    .busy_o        (busy)
  );

  ep_dma_route #(.NUM_EP(NUM_EP), .CODE_W(CODE_W)) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ack_only_i (mode_q.ack_only),
    .ack_hi_i   (mode_q.ack_hi),
    .dack_i     (dack_i),
    .tgt_hot_i  (tgt_hot),
    .tgt_dir_i  (tgt_dir),
    .io_sel_we_i(io_sel_we_i),
    .io_sel_i   (io_sel_i),
    .io_rd_i    (io_rd_i),
    .io_wr_i    (io_wr_i),
    .ep_rd_o    (ep_rd_o),
    .ep_wr_o    (ep_wr_o),
    .dma_stb_o  (dma_stb),
    .dack_act_o (dack_act)
  );
endmodule

// File: rtl/ep_dma_hs_chk.sv
module ep_dma_hs_chk #(
  parameter int unsigned NUM_EP = ep_dma_pkg::EP_N,
  parameter int unsigned CODE_W = ep_dma_pkg::CODE_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  dreq_o,
  input logic [NUM_EP-1:0]     ep_rd_o,
  input logic [NUM_EP-1:0]     ep_wr_o,
  input ep_dma_pkg::dma_mode_t mode_q,
  input logic [CODE_W-1:0]     tgt_ep,
  input logic                  busy,
  input logic                  tgt_ready,
  input logic                  dma_stb
);
  localparam int unsigned BLEN_W = ep_dma_pkg::BLEN_W;

  logic              req_act;
  logic [BLEN_W:0]   seen_q;

  assign req_act = (dreq_o == mode_q.req_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seen_q <= '0;
    else if (!req_act)   seen_q <= '0;
    else if (dma_stb)    seen_q <= seen_q + 1'b1;
  end

  // R5
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_act |-> (seen_q <= {1'b0, mode_q.blen}));

  // R4
  disabled_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.en |=> !req_act);

  // R4
  not_ready_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_act && !tgt_ready) |=> !req_act);

  // R11
  target_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(tgt_ep));

  // R6
  single_ep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ep_rd_o | ep_wr_o));
endmodule

bind ep_dma_hs ep_dma_hs_chk #(.NUM_EP(NUM_EP), .CODE_W(CODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .dreq_o   (dreq_o),
  .ep_rd_o  (ep_rd_o),
  .ep_wr_o  (ep_wr_o),
  .mode_q   (mode_q),
  .tgt_ep   (tgt_ep),
  .busy     (busy),
  .tgt_ready(tgt_ready),
  .dma_stb  (dma_stb)
);

// File: tb/ep_dma_hs_test.sv
module ep_dma_hs_test;
  localparam int CLK_P = 10;
  localparam int N     = 14;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          cfg_we_i = 0, cfg_en_i = 0, cfg_ack_only_i = 0;
  logic          cfg_req_hi_i = 1, cfg_ack_hi_i = 1;
  logic [3:0]    cfg_ep_i = '0, cfg_blen_i = '0, io_sel_i = '0;
  logic [N-1:0]  ep_dir_i = '0, ep_has_data_i = '1, ep_has_space_i = '1;
  logic          io_sel_we_i = 0, io_rd_i = 0, io_wr_i = 0, dack_i = 0;
  logic          dreq_o;
  logic [N-1:0]  ep_rd_o, ep_wr_o;
  int            checks = 0, errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  ep_dma_hs uut (.*);

  function automatic logic [N-1:0] hot(input int code);
    hot = '0;
    if (code >= 2 && code <= 15) hot[code-2] = 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i); #1;
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic set_cfg(input logic en, input int ep, input int blen,
                         input logic only, input logic rhi, input logic ahi);
    cfg_en_i = en; cfg_ep_i = 4'(ep); cfg_blen_i = 4'(blen);
    cfg_ack_only_i = only; cfg_req_hi_i = rhi; cfg_ack_hi_i = ahi;
    cfg_we_i = 1'b1;
    tick;
    cfg_we_i = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary;
    $finish;
  end

  initial begin
    int code, blen;
    logic rd, wr;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 dreq in reset", dreq_o, 0);
    rst_ni = 1'b1;
    tick; tick;
    chk("R1 dreq idle after reset", dreq_o, 0);
    io_rd_i = 1; io_wr_i = 1; settle;
    chk("R1 no io endpoint rd", ep_rd_o, 0);
    chk("R1 no io endpoint wr", ep_wr_o, 0);
    io_rd_i = 0; io_wr_i = 0;

    // R7 random I/O routing
    for (int k = 0; k < 40; k++) begin
      code = $urandom_range(15, 0);
      rd = 1'($urandom_range(1, 0));
      wr = 1'($urandom_range(1, 0));
      io_sel_i = 4'(code); io_sel_we_i = 1; tick; io_sel_we_i = 0;
      io_rd_i = rd; io_wr_i = wr; settle;
      chk("R7 io rd route", ep_rd_o, rd ? hot(code) : '0);
      chk("R7 io wr route", ep_wr_o, wr ? hot(code) : '0);
      io_rd_i = 0; io_wr_i = 0;
    end
    io_sel_i = 4'd9; io_sel_we_i = 1; tick; io_sel_we_i = 0;

    // OUT endpoint, strobe-qualified, 4-byte burst
    set_cfg(1, 5, 3, 0, 1, 1);
    chk("R4 dreq not yet", dreq_o, 0);
    tick;
    chk("R4 dreq rises", dreq_o, 1);
    dack_i = 1; settle;
    chk("R8 dack alone no strobe", ep_rd_o, 0);
    tick; tick;
    chk("R8 dack alone keeps dreq", dreq_o, 1);
    for (int s = 0; s < 4; s++) begin
      io_rd_i = 1; settle;
      chk("R6 dma strobe to target", ep_rd_o, hot(5));
      chk("R3 out uses rd only", ep_wr_o, 0);
      tick;
      chk("R5 burst dreq", dreq_o, (s < 3) ? 1 : 0);
    end
    dack_i = 0; settle;
    chk("R7 io path after dma", ep_rd_o, hot(9));
    io_rd_i = 0; tick;
    chk("R5 dreq returns after dack off", dreq_o, 1);

    // R4 buffer empties
    ep_has_data_i[3] = 0; tick;
    chk("R4 dreq drops on empty", dreq_o, 0);
    ep_has_data_i[3] = 1; tick;
    chk("R4 dreq back on data", dreq_o, 1);

    // IN endpoint code 15, single cycle
    ep_dir_i[13] = 1;
    set_cfg(1, 15, 0, 0, 1, 1);
    tick;
    chk("R2 code 15 requests", dreq_o, 1);
    dack_i = 1; io_rd_i = 1; settle;
    chk("R3 in ignores rd", ep_rd_o | ep_wr_o, 0);
    io_rd_i = 0; io_wr_i = 1; settle;
    chk("R3 in uses wr", ep_wr_o, hot(15));
    tick;
    chk("R5 single cycle drop", dreq_o, 0);
    dack_i = 0; io_wr_i = 0; tick;
    chk("R5 single cycle rearm", dreq_o, 1);
    ep_has_space_i[13] = 0; tick;
    chk("R4 dreq drops on full", dreq_o, 0);
    ep_has_space_i[13] = 1;
    ep_dir_i = '0;

    // low polarities, acknowledge-only mode, code 2
    set_cfg(0, 2, 1, 0, 0, 0);
    dack_i = 1; tick;
    set_cfg(1, 2, 1, 1, 0, 0);
    chk("R10 low dreq idle high", dreq_o, 1);
    tick;
    chk("R10 low dreq active low", dreq_o, 0);
    dack_i = 0; settle;
    chk("R9 dack edge strobes", ep_rd_o, hot(2));
    tick;
    chk("R9 strobe one cycle", ep_rd_o, 0);
    chk("R9 one byte only", dreq_o, 0);
    dack_i = 1; tick;
    dack_i = 0; settle;
    chk("R9 second dack edge", ep_rd_o, hot(2));
    tick;
    chk("R5 two-byte burst done", dreq_o, 1);
    dack_i = 1; tick;
    chk("R10 low dreq rearms", dreq_o, 0);
    set_cfg(0, 2, 0, 0, 1, 1);
    dack_i = 0; tick;

    // R11 deferred target change
    set_cfg(1, 5, 3, 0, 1, 1);
    tick;
    chk("R11 dreq up", dreq_o, 1);
    dack_i = 1; io_rd_i = 1; tick;
    dack_i = 0; io_rd_i = 0;
    set_cfg(1, 7, 3, 0, 1, 1);
    dack_i = 1; io_rd_i = 1; settle;
    chk("R11 old target kept", ep_rd_o, hot(5));
    tick; tick; tick;
    chk("R11 burst ends", dreq_o, 0);
    dack_i = 0; io_rd_i = 0; tick;
    dack_i = 1; io_rd_i = 1; settle;
    chk("R11 new target applied", ep_rd_o, hot(7));
    dack_i = 0; io_rd_i = 0; tick;

    // R5 random burst lengths
    for (int k = 0; k < 6; k++) begin
      code = $urandom_range(15, 2);
      blen = $urandom_range(15, 0);
      set_cfg(1, code, blen, 0, 1, 1);
      tick;
      chk("R5 random dreq up", dreq_o, 1);
      for (int s = 0; s <= blen; s++) begin
        dack_i = 1; io_rd_i = 1; settle;
        chk("R2 random target strobe", ep_rd_o, hot(code));
        tick;
        if (s < blen) chk("R5 random mid burst", dreq_o, 1);
      end
      chk("R5 random burst end", dreq_o, 0);
      dack_i = 0; io_rd_i = 0; tick;
      chk("R5 random rearm", dreq_o, 1);
    end

    // R4 disable, R2 invalid code
    set_cfg(0, 5, 0, 0, 1, 1);
    tick;
    chk("R4 disabled no dreq", dreq_o, 0);
    set_cfg(1, 1, 0, 0, 1, 1);
    tick; tick;
    chk("R2 code 1 no dreq", dreq_o, 0);
    dack_i = 1; io_rd_i = 1; io_wr_i = 1; settle;
    chk("R2 code 1 no strobe", ep_rd_o | ep_wr_o, 0);
    dack_i = 0; io_rd_i = 0; io_wr_i = 0;
    set_cfg(1, 0, 0, 0, 1, 1);
    tick; tick;
    chk("R2 code 0 no dreq", dreq_o, 0);

    summary;
    $finish;
  end
endmodule